// File: doc/BRIEF.md
# Receive Elastic Buffer with Controlled Frame Slip

This block decouples the recovered receive byte stream of a 32-channel, 2.048 Mbit/s link from the local backplane timing. The recovered side writes one byte per channel strobe. The backplane side reads one byte per strobe. Both sides share a single clock and are paced only by their enable strobes. In its normal mode the store holds two frames, which is 64 channel entries.

The read side can drift toward or away from the write side. The block measures the lag, which is the number of entries written but not yet read, once per read frame, at the moment the read channel index wraps. When the lag has left its window, the read pointer moves by exactly one frame. A lag that is too small repeats a frame. A lag that is too large drops a frame. Channel alignment is kept in both cases, and the block records that a slip happened and which kind it was.

A one-frame mode is selected by a static input that is sampled at reset. In this mode the store is a 32-entry store with a fixed starting delay and no frame slip. Overruns and underruns of single entries are flagged instead. The slip flags stay set until a clear strobe. An interrupt output reflects the flag, gated by a mask.

Top module: `rx_slip_buffer`

## Requirements
- R1: After reset, `slip_flag`, `slip_dir`, `irq` and `rd_data` are 0 and every store entry is 0. In two-frame mode the write pointer starts at entry 34 and the read pointer at entry 0, so the lag is 34. In one-frame mode the write pointer starts at entry 16 and the fill count is 16.
- R2: `rd_en` reads the entry at the read pointer. The value appears on `rd_data` after the next clock edge. Without `rd_en`, `rd_data` holds its value. When a read and a write hit the same entry in the same cycle, the read returns the old content.
- R3: In two-frame mode both pointers step through 64 entries and wrap from 63 to 0. Data come out in the order they were written.
- R4: In two-frame mode, the lag is examined only on a read of channel 31 (read pointer bits [4:0] all ones). The lag is (write pointer after this cycle's write − read pointer after this read's increment) mod 64. No slip happens at any other read.
- R5: If the examined lag is 2 or less, the read pointer moves back one frame (32 entries) and the last frame is repeated. `slip_dir` becomes 1.
- R6: If the examined lag is greater than 60, the read pointer moves forward one frame and a frame is lost. `slip_dir` becomes 0.
- R7: An examined lag from 3 to 60 inclusive causes no slip.
- R8: `slip_flag` is set by any slip or flagged error and stays set until a `slip_clr` cycle with no new event. `slip_clr` also resets `slip_dir` to 0. If an event and `slip_clr` fall in the same cycle, the event wins.
- R9: `irq` is high exactly when `slip_flag` is 1 and `irq_mask` is 0.
- R10: In one-frame mode (`one_frame`=1, held through reset), the pointers wrap at 32 and no frame slip occurs. A fill count tracks the entries written and not yet read. It is 0 to 32.
- R11: In one-frame mode, a write without a read at fill 32 overwrites the oldest unread entry. That entry is lost. The write sets the flag with `slip_dir`=0 and the fill stays 32.
- R12: In one-frame mode, a read without a write at fill 0 re-reads an already read entry. The read sets the flag with `slip_dir`=1 and the fill stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| one_frame | input | 1 | 1 selects one-frame mode; static, sampled during reset |
| wr_en | input | 1 | Write strobe from the recovered receive side |
| wr_data | input | DW | Channel byte to store |
| rd_en | input | 1 | Read strobe from the backplane side |
| rd_data | output | DW | Registered channel byte read out |
| slip_clr | input | 1 | Clears the sticky slip flag and direction |
| irq_mask | input | 1 | 1 masks the interrupt |
| slip_flag | output | 1 | Sticky slip / error indication |
| slip_dir | output | 1 | 1 means an entry or frame was repeated; 0 means one was lost |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its default parameters: an 8-bit width, 32 channels per frame, marks of 2 and 60, and a starting lag of 34. Under these defaults the hand-worked lags of 2, 3, 60 and 61 fall exactly on frame boundaries. The same defaults make a lag of 0 reachable in mid-frame without a slip. Both the two-frame and one-frame variants are reached through the `one_frame` input at reset, so one build covers the slip thresholds, the 64-entry wrap, and single-entry overrun and underrun. Long runs with strobes skipped in a regular pattern drive the lag slowly in both directions, with random data, while a behavioural model tracks every cycle.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

    typedef enum logic {
        DIR_LOST   = 1'b0,
        DIR_REPEAT = 1'b1
    } slip_dir_e;

endpackage

// File: rtl/rsb_store.sv
module rsb_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [DW-1:0]            q;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (re) begin
            st_d.q = st_q.mem[raddr];
        end
        if (we) begin
            st_d.mem[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.q;

endmodule

// File: rtl/rsb_ptr_ctrl.sv
module rsb_ptr_ctrl
    import rsb_pkg::*;
#(
    parameter int FRAME_CH         = 32,
    parameter int AW               = 6,
    parameter int CW               = 5,
    parameter int LOW_MARK         = 2,
    parameter int HIGH_MARK        = 60,
    parameter int RESET_LAG        = 34,
    parameter int SINGLE_RESET_LAG = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          one_frame,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          slip_clr,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic          slip_evt,
    output logic          slip_flag,
    output logic          slip_dir
);

    localparam logic [AW-1:0] LOW_L   = AW'(LOW_MARK);
    localparam logic [AW-1:0] HIGH_L  = AW'(HIGH_MARK);
    localparam logic [AW-1:0] FRAME_L = AW'(FRAME_CH);
    localparam logic [CW-1:0] LAST_CH = CW'(FRAME_CH - 1);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [AW-1:0] fill;
        logic          flag;
        slip_dir_e     dir;
    } ctrl_t;

    ctrl_t         st_d, st_q;
    logic [AW-1:0] wr_inc_d, rd_inc_d, lag_d;
    logic          evt_d;
    slip_dir_e     evt_dir_d;

    always_comb begin
        st_d      = st_q;
        evt_d     = 1'b0;
        evt_dir_d = DIR_LOST;
        lag_d     = '0;

        wr_inc_d = st_q.wr_ptr + AW'(1);
        rd_inc_d = st_q.rd_ptr + AW'(1);
        if (one_frame) begin
            wr_inc_d[AW-1] = 1'b0;
            rd_inc_d[AW-1] = 1'b0;
        end

        if (wr_en) st_d.wr_ptr = wr_inc_d;
        if (rd_en) st_d.rd_ptr = rd_inc_d;

        if (one_frame) begin
            if (wr_en && !rd_en) begin
                if (st_q.fill == FRAME_L) begin
                    evt_d     = 1'b1;
                    evt_dir_d = DIR_LOST;
                end else begin
                    st_d.fill = st_q.fill + AW'(1);
                end
            end else if (rd_en && !wr_en) begin
                if (st_q.fill == '0) begin
                    evt_d     = 1'b1;
                    evt_dir_d = DIR_REPEAT;
                end else begin
                    st_d.fill = st_q.fill - AW'(1);
                end
            end
        end else if (rd_en && (st_q.rd_ptr[CW-1:0] == LAST_CH)) begin
            lag_d = st_d.wr_ptr - rd_inc_d;
            if (lag_d <= LOW_L) begin
                st_d.rd_ptr = rd_inc_d - FRAME_L;
                evt_d       = 1'b1;
                evt_dir_d   = DIR_REPEAT;
            end else if (lag_d > HIGH_L) begin
                st_d.rd_ptr = rd_inc_d + FRAME_L;
                evt_d       = 1'b1;
                evt_dir_d   = DIR_LOST;
            end
        end

        if (evt_d) begin
            st_d.flag = 1'b1;
            st_d.dir  = evt_dir_d;
        end else if (slip_clr) begin
            st_d.flag = 1'b0;
            st_d.dir  = DIR_LOST;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.wr_ptr <= one_frame ? AW'(SINGLE_RESET_LAG) : AW'(RESET_LAG);
            st_q.rd_ptr <= '0;
            st_q.fill   <= AW'(SINGLE_RESET_LAG);
            st_q.flag   <= 1'b0;
            st_q.dir    <= DIR_LOST;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr    = st_q.wr_ptr;
    assign rd_ptr    = st_q.rd_ptr;
    assign slip_evt  = evt_d;
    assign slip_flag = st_q.flag;
    assign slip_dir  = st_q.dir;

endmodule

// File: rtl/rx_slip_buffer.sv
module rx_slip_buffer #(
    parameter int DW               = 8,
    parameter int FRAME_CH         = 32,
    parameter int LOW_MARK         = 2,
    parameter int HIGH_MARK        = 60,
    parameter int RESET_LAG        = 34,
    parameter int SINGLE_RESET_LAG = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          one_frame,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic          slip_clr,
    input  logic          irq_mask,
    output logic          slip_flag,
    output logic          slip_dir,
    output logic          irq
);

    localparam int DEPTH = 2 * FRAME_CH;
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = $clog2(FRAME_CH);

    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          slip_evt;

    rsb_ptr_ctrl #(
        .FRAME_CH        (FRAME_CH),
        .AW              (AW),
        .CW              (CW),
        .LOW_MARK        (LOW_MARK),
        .HIGH_MARK       (HIGH_MARK),
        .RESET_LAG       (RESET_LAG),
        .SINGLE_RESET_LAG(SINGLE_RESET_LAG)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .one_frame(one_frame),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .slip_clr (slip_clr),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .slip_evt (slip_evt),
        .slip_flag(slip_flag),
        .slip_dir (slip_dir)
    );

    rsb_store #(
        .DW   (DW),
        .DEPTH(DEPTH),
        .AW   (AW)
    ) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wr_en),
        .waddr(wr_ptr),
        .wdata(wr_data),
        .re   (rd_en),
        .raddr(rd_ptr),
        .rdata(rd_data)
    );

    assign irq = slip_flag & ~irq_mask;

endmodule

// File: rtl/rsb_checker.sv
module rsb_checker #(
    parameter int DW = 8,
    parameter int AW = 6,
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          one_frame,
    input logic          rd_en,
    input logic          slip_clr,
    input logic          irq_mask,
    input logic          slip_evt,
    input logic          slip_flag,
    input logic          irq,
    input logic [AW-1:0] wr_ptr,
    input logic [AW-1:0] rd_ptr,
    input logic [DW-1:0] rd_data
);

    // R2: output register only moves on a read
    assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R4: frame slip only at the read frame boundary
    assert_slip_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_evt && !one_frame) |-> (rd_en && (&rd_ptr[CW-1:0])));

    // R8: an event always leaves the flag set
    assert_event_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slip_evt |=> slip_flag);

    // R8: clear without event drops the flag
    assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_clr && !slip_evt) |=> !slip_flag);

    // R8: flag is sticky otherwise
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!slip_clr && !slip_evt) |=> $stable(slip_flag));

    // R9: interrupt implies flag, mask blocks it
    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> slip_flag);
    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !irq);

    // R10: one-frame mode keeps both pointers in the lower frame
    assert_single_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        one_frame |-> (!wr_ptr[AW-1] && !rd_ptr[AW-1]));

endmodule

bind rx_slip_buffer rsb_checker #(.DW(DW), .AW(AW), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .one_frame(one_frame),
    .rd_en    (rd_en),
    .slip_clr (slip_clr),
    .irq_mask (irq_mask),
    .slip_evt (slip_evt),
    .slip_flag(slip_flag),
    .irq      (irq),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .rd_data  (rd_data)
);

// File: tb/rx_slip_buffer_test.sv
module rx_slip_buffer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       one_frame = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       slip_clr = 1'b0;
    logic       irq_mask = 1'b0;
    logic       slip_flag, slip_dir, irq;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rx_slip_buffer uut (
        .clk(clk), .rst_n(rst_n), .one_frame(one_frame),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .slip_clr(slip_clr), .irq_mask(irq_mask),
        .slip_flag(slip_flag), .slip_dir(slip_dir), .irq(irq)
    );

    // behavioural reference
    int         mmem [64];
    int         mwp, mrp, mfill;
    logic [7:0] mdata;
    bit         mflag, mdir;

    always @(posedge clk) begin
        int sz, wpn, rpn, lag;
        bit ev, evdir;
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mmem[i] = 0;
            mwp = one_frame ? 16 : 34;
            mrp = 0; mfill = 16; mdata = 0; mflag = 0; mdir = 0;
        end else begin
            sz = one_frame ? 32 : 64;
            ev = 0; evdir = 0;
            if (rd_en) mdata = 8'(mmem[mrp]);
            if (wr_en) mmem[mwp] = int'(wr_data);
            wpn = wr_en ? (mwp + 1) % sz : mwp;
            rpn = rd_en ? (mrp + 1) % sz : mrp;
            if (one_frame) begin
                if (wr_en && !rd_en) begin
                    if (mfill == 32) begin ev = 1; evdir = 0; end
                    else mfill++;
                end else if (rd_en && !wr_en) begin
                    if (mfill == 0) begin ev = 1; evdir = 1; end
                    else mfill--;
                end
            end else if (rd_en && (mrp % 32) == 31) begin
                lag = (wpn - rpn + 64) % 64;
                if (lag <= 2) begin rpn = (rpn + 32) % 64; ev = 1; evdir = 1; end
                else if (lag > 60) begin rpn = (rpn + 32) % 64; ev = 1; evdir = 0; end
            end
            if (ev) begin mflag = 1; mdir = evdir; end
            else if (slip_clr) begin mflag = 0; mdir = 0; end
            mwp = wpn; mrp = rpn;
        end
    end

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 R3 rd_data vs model", int'(rd_data), int'(mdata));
            chk("R8 slip_flag vs model", int'(slip_flag), int'(mflag));
            chk("R5 R6 R11 R12 slip_dir vs model", int'(slip_dir), int'(mdir));
            chk("R9 irq vs model", int'(irq), int'(mflag && !irq_mask));
        end
    end

    task automatic cyc(bit w, bit r, logic [7:0] d, bit c);
        wr_en = w; rd_en = r; wr_data = d; slip_clr = c;
        @(posedge clk); #2;
        wr_en = 0; rd_en = 0; slip_clr = 0;
    endtask

    task automatic run(int n, bit w, bit r);
        for (int i = 0; i < n; i++) cyc(w, r, 8'($urandom), 0);
    endtask

    task automatic do_reset(bit single);
        rst_n = 0; one_frame = single; irq_mask = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
    endtask

    initial begin
        #1600000;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset(0);
        chk("R1 slip_flag after reset", int'(slip_flag), 0);
        chk("R1 slip_dir after reset", int'(slip_dir), 0);
        chk("R1 irq after reset", int'(irq), 0);
        chk("R1 rd_data after reset", int'(rd_data), 0);

        // R2 R3 ordering and 64-entry wrap
        for (int i = 0; i < 65; i++) begin
            cyc(1, 1, 8'(i + 1), 0);
            if (i == 34) chk("R2 first written byte read at lag 34", int'(rd_data), 1);
            if (i == 64) chk("R3 entry 0 after write wrap", int'(rd_data), 31);
        end
        chk("R7 steady lag 34 no slip", int'(slip_flag), 0);

        // R5 repeat slip at lag 2
        do_reset(0);
        run(31, 0, 1);
        chk("R7 mid-frame lag 3 no slip", int'(slip_flag), 0);
        run(1, 0, 1);
        chk("R5 slip flag at lag 2", int'(slip_flag), 1);
        chk("R5 direction repeat", int'(slip_dir), 1);
        chk("R9 irq unmasked", int'(irq), 1);
        irq_mask = 1;
        cyc(0, 0, 0, 0);
        chk("R9 irq masked", int'(irq), 0);
        chk("R8 flag sticky", int'(slip_flag), 1);
        irq_mask = 0;
        cyc(0, 0, 0, 1);
        chk("R8 clear strobe", int'(slip_flag), 0);
        chk("R8 clear resets dir", int'(slip_dir), 0);

        // R7 lag 3 at boundary
        do_reset(0);
        cyc(1, 0, 8'h07, 0);
        run(32, 0, 1);
        chk("R7 boundary lag 3 no slip", int'(slip_flag), 0);

        // R6 drop slip at lag 61, R7 lag 60
        do_reset(0);
        run(26, 1, 0);
        run(32, 1, 1);
        chk("R7 boundary lag 60 no slip", int'(slip_flag), 0);
        run(1, 1, 0);
        run(32, 1, 1);
        chk("R6 slip flag at lag 61", int'(slip_flag), 1);
        chk("R6 direction lost", int'(slip_dir), 0);
        cyc(0, 0, 0, 1);
        run(29, 0, 1);
        chk("R4 lag 0 mid-frame no slip", int'(slip_flag), 0);
        run(2, 0, 1);
        cyc(0, 1, 0, 1);
        chk("R8 event beats clear", int'(slip_flag), 1);
        chk("R6 drop on lag 61 again", int'(slip_dir), 0);

        // slow drift both ways, two-frame mode
        do_reset(0);
        for (int i = 0; i < 3000; i++)
            cyc((i < 1500) ? (i % 40 != 7) : 1'b1, (i < 1500) ? 1'b1 : (i % 40 != 7), 8'($urandom), (i % 300 == 299));

        // one-frame mode
        do_reset(1);
        for (int i = 0; i < 16; i++) cyc(1, 0, 8'(i + 1), 0);
        chk("R10 fill 32 no flag", int'(slip_flag), 0);
        cyc(1, 0, 8'd17, 0);
        chk("R11 overflow flag", int'(slip_flag), 1);
        chk("R11 overflow direction lost", int'(slip_dir), 0);
        cyc(0, 0, 0, 1);
        cyc(0, 1, 0, 0);
        chk("R11 oldest entry overwritten", int'(rd_data), 17);
        run(31, 0, 1);
        chk("R10 no frame slip across boundary", int'(slip_flag), 0);
        cyc(0, 1, 0, 0);
        chk("R12 underflow flag", int'(slip_flag), 1);
        chk("R12 underflow direction repeat", int'(slip_dir), 1);

        // random one-frame traffic
        for (int i = 0; i < 2000; i++)
            cyc(1'($urandom), 1'($urandom), 8'($urandom), ($urandom % 8) == 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule